// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block gathers eleven level-sensitive interrupt lines and turns each fresh assertion into a single 32-bit memory-write message on a master port. Every line has a level bit that follows the input and a sticky pending bit that captures each rising edge. It also has a bit in a mask register that allows or suppresses messages, and a bit in a class register that picks one of two message-address registers. Each address register supplies both the message target and the message payload. The target is the register value with its five low bits cleared. The payload is those five low bits.

Software reaches the state through a simple word-indexed register port. A read or a write of the pending register clears it. Two request views are computed when they are read: active, enabled lines of class 0 and of class 1. The message port uses a valid/ready handshake. Messages that fall due while the port is stalled wait in a FIFO and leave in the order their edges were seen.

Top module: `irqmsg_top`

## Requirements
- R1: Reset clears every register (level, mask, pending, class, both address registers). No message is valid while reset is applied, and none is valid just after it.
- R2: Register word index on `reg_addr`: 0 level (read-only), 1 mask, 2 pending, 3 class, 4 address 0, 5 address 1, 6 request view 0 (read-only), 7 request view 1 (read-only). Source i occupies bit i, and upper data bits read as 0. Read data appears one clock edge after the read strobe.
- R3: A source going from 0 to 1 sets its level bit and its pending bit. A source going from 1 to 0 clears only its level bit.
- R4: A message is produced only for a newly asserted source whose mask bit is 1. A source held high, or an unmasked-off source, produces no message.
- R5: A source whose class bit is 1 uses address register 1. A source whose class bit is 0 uses address register 0.
- R6: The message address is the chosen register with bits 4:0 cleared. The message data is bits 4:0 of that register, zero-extended.
- R7: A read of the pending register returns its value and clears it. A write to the pending register clears it, whatever the data.
- R8: Request view 0 reads level AND mask AND NOT class. Request view 1 reads level AND mask AND class.
- R9: Writes to the level register and to both request views have no effect.
- R10: While `msg_ready` is low, the message address and data hold steady. Further due messages queue in a FIFO of `DEPTH` entries and issue in the order their edges were detected. Edges detected in the same cycle issue lowest source index first.
- R11: A message becomes valid on the clock edge that samples the new source level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Level-sensitive interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one edge after the strobe |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high together with valid |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
A source change is captured on one rising edge. The resulting message is valid right after that edge, and the level and pending bits change on the same edge. Register read data is due one edge after the strobe. The bench therefore drives every input on a falling edge and samples every output on the following falling edge. A pop happens on the edge between two falling edges where the bench holds `msg_ready` high, and no check samples across an edge it has not counted.

// File: rtl/irqmsg_pkg.sv
package irqmsg_pkg;

  typedef enum logic [2:0] {
    RG_LEVEL = 3'd0,
    RG_MASK  = 3'd1,
    RG_PEND  = 3'd2,
    RG_CLASS = 3'd3,
    RG_ADDR0 = 3'd4,
    RG_ADDR1 = 3'd5,
    RG_REQ0  = 3'd6,
    RG_REQ1  = 3'd7
  } reg_sel_e;

  // target of a message: the programmed word with its 5 low bits dropped
  function automatic logic [31:0] msg_target(input logic [31:0] r);
    return {r[31:5], 5'd0};
  endfunction

  // payload of a message: the 5 low bits of the programmed word
  function automatic logic [31:0] msg_payload(input logic [31:0] r);
    return {27'd0, r[4:0]};
  endfunction

endpackage

// File: rtl/irqmsg_edge.sv
module irqmsg_edge #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  output logic [NSRC-1:0] level,
  output logic [NSRC-1:0] rise
);

  logic [NSRC-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= src;
  end

  assign level = level_q;
  assign rise  = src & ~level_q;

endmodule

// File: rtl/irqmsg_regs.sv
module irqmsg_regs
  import irqmsg_pkg::*;
#(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2:0]      addr,
  input  logic [31:0]     wdata,
  input  logic [NSRC-1:0] level,
  input  logic [NSRC-1:0] rise,
  output logic [31:0]     rdata,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] cls,
  output logic [NSRC-1:0] pend,
  output logic [31:0]     addr0,
  output logic [31:0]     addr1
);

  function automatic logic [31:0] zx(input logic [NSRC-1:0] v);
    return 32'(v);
  endfunction

  logic [31:0] rd_mux;
  logic        pend_clr;
  logic        wr_mask, wr_cls, wr_a0, wr_a1;

  assign pend_clr = (wr_en || rd_en) && (addr == RG_PEND);
  assign wr_mask  = wr_en && (addr == RG_MASK);
  assign wr_cls   = wr_en && (addr == RG_CLASS);
  assign wr_a0    = wr_en && (addr == RG_ADDR0);
  assign wr_a1    = wr_en && (addr == RG_ADDR1);

  always_comb begin
    case (reg_sel_e'(addr))
      RG_LEVEL: rd_mux = zx(level);
      RG_MASK:  rd_mux = zx(mask);
      RG_PEND:  rd_mux = zx(pend);
      RG_CLASS: rd_mux = zx(cls);
      RG_ADDR0: rd_mux = addr0;
      RG_ADDR1: rd_mux = addr1;
      RG_REQ0:  rd_mux = zx(level & mask & ~cls);
      RG_REQ1:  rd_mux = zx(level & mask & cls);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask  <= '0;
      cls   <= '0;
      pend  <= '0;
      addr0 <= '0;
      addr1 <= '0;
      rdata <= '0;
    end else begin
      if (wr_mask) mask  <= wdata[NSRC-1:0];
      if (wr_cls)  cls   <= wdata[NSRC-1:0];
      if (wr_a0)   addr0 <= wdata;
      if (wr_a1)   addr1 <= wdata;
      pend <= (pend_clr ? '0 : pend) | rise;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // a read of pending with no fresh edge leaves it empty
  assert_pend_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == RG_PEND && rise == '0) |=> (pend == '0));

  // read data of pending equals what pending held at the strobe
  assert_pend_read_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == RG_PEND) |=> (rdata == zx($past(pend))));

endmodule

// File: rtl/irqmsg_fifo.sv
module irqmsg_fifo #(
  parameter int NSRC  = 11,
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       due,
  input  logic [NSRC-1:0][31:0] cand,
  input  logic                  ready,
  output logic                  valid,
  output logic [31:0]           head
);

  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = PW + 1;
  localparam int CW   = $clog2(NSRC + 1);
  localparam int WW   = ((CW > CNTW) ? CW : CNTW) + 1;

  logic [31:0]     mem [DEPTH];
  logic [PW-1:0]   rptr, wptr;
  logic [CNTW-1:0] count;
  logic [CW-1:0]   ofs [NSRC];
  logic [CW-1:0]   total;
  logic [WW-1:0]   free_w, push_w;
  logic            pop;

  // slot offset of each due source: number of due sources below it
  always_comb begin
    ofs[0] = '0;
    for (int i = 1; i < NSRC; i++) ofs[i] = ofs[i-1] + CW'(due[i-1]);
    total  = ofs[NSRC-1] + CW'(due[NSRC-1]);
    free_w = WW'(DEPTH) - WW'(count);
    push_w = (WW'(total) < free_w) ? WW'(total) : free_w;
  end

  assign valid = (count != '0);
  assign head  = mem[rptr];
  assign pop   = valid && ready;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSRC; i++) begin
      if (due[i] && (WW'(ofs[i]) < free_w)) mem[wptr + PW'(ofs[i])] <= cand[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wptr  <= '0;
      rptr  <= '0;
    end else begin
      count <= count + CNTW'(push_w) - CNTW'(pop);
      wptr  <= wptr + PW'(push_w);
      rptr  <= rptr + PW'(pop);
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));

  // a stalled head entry is not consumed
  assert_stall_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (rptr == $past(rptr)));

endmodule

// File: rtl/irqmsg_top.sv
module irqmsg_top
  import irqmsg_pkg::*;
#(
  parameter int NSRC  = 11,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [31:0]     msg_addr,
  output logic [31:0]     msg_data
);

  logic [NSRC-1:0]       level, rise, mask, cls, pend, due;
  logic [31:0]           addr0, addr1, head;
  logic [NSRC-1:0][31:0] cand;

  irqmsg_edge #(.NSRC(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .level(level), .rise(rise)
  );

  irqmsg_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .level(level), .rise(rise),
    .rdata(reg_rdata), .mask(mask), .cls(cls), .pend(pend),
    .addr0(addr0), .addr1(addr1)
  );

  assign due = rise & mask;

  for (genvar g = 0; g < NSRC; g++) begin : g_pick
    assign cand[g] = cls[g] ? addr1 : addr0;
  end

  irqmsg_fifo #(.NSRC(NSRC), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .due(due), .cand(cand),
    .ready(msg_ready), .valid(msg_valid), .head(head)
  );

  assign msg_addr = msg_target(head);
  assign msg_data = msg_payload(head);

  assert_edge_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));

  assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && (rise & mask) == '0) |=> !msg_valid);

  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_due_issues_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & mask) != '0) |=> msg_valid);

endmodule

// File: tb/sim_irqmsg_top.sv
module sim_irqmsg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq_src = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  irqmsg_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  localparam logic [2:0] A_LVL = 3'd0, A_MSK = 3'd1, A_PND = 3'd2, A_CLS = 3'd3,
                         A_AD0 = 3'd4, A_AD1 = 3'd5, A_RQ0 = 3'd6, A_RQ1 = 3'd7;

  // entry: {write?, index, data-or-expected}
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, A_MSK, 32'hFFFF_F4FF}, {1'b0, A_MSK, 32'h0000_04FF},
    {1'b1, A_CLS, 32'h0000_0005}, {1'b0, A_CLS, 32'h0000_0005},
    {1'b1, A_AD0, 32'h0000_1234}, {1'b0, A_AD0, 32'h0000_1234},
    {1'b1, A_AD1, 32'hABCD_EF1F}, {1'b0, A_AD1, 32'hABCD_EF1F},
    {1'b1, A_LVL, 32'h0000_07FF}, {1'b0, A_LVL, 32'h0000_0000},
    {1'b1, A_RQ0, 32'h0000_07FF}, {1'b0, A_RQ0, 32'h0000_0000},
    {1'b1, A_RQ1, 32'h0000_07FF}, {1'b0, A_RQ1, 32'h0000_0000}
  };

  localparam logic [31:0] T0 = 32'h0000_1220, D0 = 32'h0000_0014;
  localparam logic [31:0] T1 = 32'hABCD_EF00, D1 = 32'h0000_001F;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_src(input logic [10:0] v);
    @(negedge clk);
    irq_src = v;
  endtask

  // called at a falling edge: check the head message and pop it
  task automatic expect_msg(input string req, input logic [31:0] a, input logic [31:0] d);
    check({req, " valid"}, 32'(msg_valid), 32'd1);
    check({req, " addr"}, msg_addr, a);
    check({req, " data"}, msg_data, d);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(msg_valid), 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      reg_read(3'(k), got);
      check("R1 register zero after reset", got, 32'd0);
    end
    check("R1 no message after reset", 32'(msg_valid), 32'd0);

    // R2 and R9: table of register accesses
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][35]) reg_write(VEC[k][34:32], VEC[k][31:0]);
      else begin
        reg_read(VEC[k][34:32], got);
        check("R2 R9 table", got, VEC[k][31:0]);
      end
    end

    // R11 R5 R6: class 0 edge on bit 1
    set_src(11'h002);
    @(negedge clk);
    expect_msg("R5 R6 R11 class0", T0, D0);
    repeat (3) @(negedge clk);
    check("R4 held source silent", 32'(msg_valid), 32'd0);
    reg_read(A_LVL, got); check("R3 level set", got, 32'h002);
    reg_read(A_PND, got); check("R3 R7 pending read", got, 32'h002);
    reg_read(A_PND, got); check("R7 pending cleared by read", got, 32'h000);

    // R5: class 1 edge on bit 0
    set_src(11'h003);
    @(negedge clk);
    expect_msg("R5 R6 class1", T1, D1);

    // R4: bit 8 is masked off
    set_src(11'h103);
    @(negedge clk);
    check("R4 masked source silent", 32'(msg_valid), 32'd0);
    reg_read(A_PND, got); check("R3 pending bits 0 and 8", got, 32'h101);

    // R8: request views, level 0x103, mask 0x4FF, class 0x005
    reg_read(A_RQ0, got); check("R8 view0", got, 32'h002);
    reg_read(A_RQ1, got); check("R8 view1", got, 32'h001);

    // R3: falling edge clears only level
    set_src(11'h101);
    @(negedge clk);
    check("R3 fall no message", 32'(msg_valid), 32'd0);
    reg_read(A_LVL, got); check("R3 level after fall", got, 32'h101);
    reg_read(A_PND, got); check("R3 fall leaves pending", got, 32'h000);

    // R7: write clears pending whatever the data
    set_src(11'h109);
    @(negedge clk);
    expect_msg("R5 class0 bit3", T0, D0);
    reg_write(A_PND, 32'h0000_0000);
    reg_read(A_PND, got); check("R7 pending cleared by write", got, 32'h000);

    // R9: level write ignored
    reg_write(A_LVL, 32'h0);
    reg_read(A_LVL, got); check("R9 level write ignored", got, 32'h109);

    // R10: queue, order and stall hold; class 0x025 gives bits 2,5 class1
    reg_write(A_CLS, 32'h0000_0025);
    set_src(11'h000);
    @(negedge clk);
    check("R4 idle", 32'(msg_valid), 32'd0);
    set_src(11'h034);
    @(negedge clk);
    check("R10 head addr", msg_addr, T1);
    set_src(11'h074);
    @(negedge clk);
    check("R10 stalled addr held", msg_addr, T1);
    check("R10 stalled data held", msg_data, D1);
    expect_msg("R10 order bit2", T1, D1);
    expect_msg("R10 order bit4", T0, D0);
    expect_msg("R10 order bit5", T1, D1);
    expect_msg("R10 order bit6", T0, D0);
    check("R10 queue drained", 32'(msg_valid), 32'd0);

    // R1: reset in mid-run with a queued message
    set_src(11'h474);
    @(negedge clk);
    check("R11 bit10 queued", 32'(msg_valid), 32'd1);
    rst_n = 1'b0;
    irq_src = '0;
    @(negedge clk);
    check("R1 reset drops message", 32'(msg_valid), 32'd0);
    rst_n = 1'b1;
    reg_read(A_MSK, got); check("R1 mask zero", got, 32'd0);
    reg_read(A_AD1, got); check("R1 addr1 zero", got, 32'd0);
    reg_read(A_LVL, got); check("R1 level zero", got, 32'd0);
    reg_read(A_PND, got); check("R1 pending zero", got, 32'd0);
    check("R1 no message after reset", 32'(msg_valid), 32'd0);

    summary();
    $finish;
  end

endmodule